// File: doc/BRIEF.md
# Smart Card Character Codec

This block moves one asynchronous smart card character onto and off a single-wire line. A character is a low start bit, eight data bits and a parity bit. The line idles high. Three static inputs set the character convention. `msb_first` reverses the order in which the data bits go out. `data_inv` complements the eight data bits on the line. `parity_odd` picks odd rather than even parity. The start bit and the parity bit are never inverted. Inverse convention is therefore reached by setting all three inputs together.

The transmit side takes a byte through a valid/ready handshake. It then steps the line once per pulse of an external one-cycle `bit_tick`. The receive side measures the tick spacing and waits for a falling edge on `rx_line`. It samples each bit near its midpoint, undoes the reversal and inversion, and presents the logical byte with a one-cycle strobe. A parity mismatch sets a sticky error flag, and the byte is still delivered.

Top module: `sc_char_codec`

## Requirements
- R1: After reset, `tx_line` and `tx_ready` are high, and `rx_valid` and `par_err` are low.
- R2: A byte is accepted on a rising clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is low from the following cycle until the 11th tick after acceptance, which is the tick that ends the parity bit.
- R3: After acceptance, the line changes only at tick edges. The first tick drives the start bit (low). The next eight ticks drive the data bits, the tenth drives the parity bit and the eleventh returns the line high.
- R4: With `msb_first`=0 the data bits leave D0 first. With `msb_first`=1 they leave D7 first.
- R5: `data_inv`=1 complements exactly the eight data bits on the line. The start bit and the parity bit are not affected.
- R6: The parity bit makes the count of high bits among the eight line data bits plus parity even when `parity_odd`=0 and odd when `parity_odd`=1.
- R7: In direct convention, byte 0x3B gives the line sequence start..parity = 0,1,1,0,1,1,1,0,0,1. In inverse convention (all three inputs high), byte 0x3F gives 0,1,1,0,0,0,0,0,0,1.
- R8: A received character is returned as the logical byte, with reversal and inversion undone under the current convention inputs. `rx_valid` pulses for exactly one cycle with `rx_data`.
- R9: A received parity mismatch sets `par_err`, and the byte is still delivered. `par_err` stays set through later good characters until `par_err_clr` is pulsed. A set in the same cycle wins over the clear.
- R10: A low pulse on `rx_line` that is shorter than half a bit is rejected as a false start and produces no `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| msb_first | input | 1 | Send and receive data MSB first |
| data_inv | input | 1 | Complement data bits on the line |
| parity_odd | input | 1 | Odd parity when high, even when low |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Transmitter free to accept |
| tx_line | output | 1 | Serial output, idles high |
| rx_line | input | 1 | Serial input, idles high |
| par_err_clr | input | 1 | Clears the sticky parity error |
| rx_data | output | 8 | Received logical byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| par_err | output | 1 | Sticky parity error |

## Verification
`tx_ready` falls one edge after the accepting edge. Each line bit appears at the edge that consumes a tick. The bench therefore waits for a tick to be raised, lets one rising edge pass, and samples the line at the next falling edge. On receive, `rx_valid` rises near the midpoint of the parity bit, about half a bit plus two synchroniser cycles after that bit begins. This is before the tick that ends the transmitted parity bit. A falling-edge monitor records every strobe, so each loopback result is checked once the transmit sequence has finished. Directly driven frames are followed by two idle bit times before the check. The clear is checked one falling edge after its pulse.

// File: rtl/sc_char_codec.sv
module sc_char_codec #(
  parameter int CW = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       msb_first,
  input  logic       data_inv,
  input  logic       parity_odd,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic       tx_line,
  input  logic       rx_line,
  input  logic       par_err_clr,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       par_err
);

  function automatic logic [7:0] order(input logic [7:0] v, input logic rev);
    logic [7:0] o;
    for (int i = 0; i < 8; i++) o[i] = rev ? v[7-i] : v[i];
    return o;
  endfunction

  logic          tx_busy;
  logic [3:0]    tx_cnt;
  logic [9:0]    tx_frame;
  logic [CW-1:0] since_tick, period, rx_timer;
  logic [2:0]    rx_sync;
  logic          rx_busy;
  logic [3:0]    rx_idx;
  logic [7:0]    rx_sh;

  wire       accept  = tx_valid & tx_ready;
  wire [7:0] tx_bits = order(tx_data, msb_first) ^ {8{data_inv}};
  wire       rx_cur  = rx_sync[1];
  wire       fall    = rx_sync[2] & ~rx_cur;
  wire       sample  = rx_busy && (rx_timer == '0);
  wire       rx_done = sample && (rx_idx == 4'd9);
  wire       rx_bad  = ((^rx_sh) ^ rx_cur) != parity_odd;

  assign tx_ready = ~tx_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_busy  <= 1'b0;
      tx_cnt   <= '0;
      tx_frame <= '1;
      tx_line  <= 1'b1;
    end else if (accept) begin
      tx_busy  <= 1'b1;
      tx_cnt   <= '0;
      tx_frame <= {(^tx_bits) ^ parity_odd, tx_bits, 1'b0};
    end else if (tx_busy && bit_tick) begin
      if (tx_cnt == 4'd10) begin
        tx_line <= 1'b1;
        tx_busy <= 1'b0;
      end else begin
        tx_line <= tx_frame[tx_cnt];
        tx_cnt  <= tx_cnt + 4'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_tick <= '0;
      period     <= '0;
    end else if (bit_tick) begin
      period     <= since_tick + 1'b1;
      since_tick <= '0;
    end else begin
      since_tick <= since_tick + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sync  <= 3'b111;
      rx_busy  <= 1'b0;
      rx_idx   <= '0;
      rx_timer <= '0;
      rx_sh    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      par_err  <= 1'b0;
    end else begin
      rx_sync  <= {rx_sync[1:0], rx_line};
      rx_valid <= rx_done;
      if (!rx_busy) begin
        if (fall) begin
          rx_busy  <= 1'b1;
          rx_idx   <= '0;
          rx_timer <= period >> 1;
        end
      end else if (sample) begin
        rx_timer <= period - 1'b1;
        if (rx_idx == 4'd0 && rx_cur) begin
          rx_busy <= 1'b0;
        end else if (rx_done) begin
          rx_busy <= 1'b0;
          rx_data <= order(rx_sh, msb_first) ^ {8{data_inv}};
        end else begin
          if (rx_idx != 4'd0) rx_sh[3'(rx_idx - 4'd1)] <= rx_cur;
          rx_idx <= rx_idx + 4'd1;
        end
      end else begin
        rx_timer <= rx_timer - 1'b1;
      end
      if (rx_done && rx_bad) par_err <= 1'b1;
      else if (par_err_clr)  par_err <= 1'b0;
    end
  end

  // R3
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_line);
  // R3
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(tx_line));
  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !par_err_clr) |=> par_err);
  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err_clr && !rx_done) |=> !par_err);

endmodule

// File: tb/sim_sc_char_codec.sv
module sim_sc_char_codec;
  localparam int P = 16;

  logic clk = 0, rst_n = 0, bit_tick = 0;
  logic msb_first = 0, data_inv = 0, parity_odd = 0;
  logic [7:0] tx_data = 0;
  logic tx_valid = 0, par_err_clr = 0, loop = 1, drv = 1;
  logic tx_ready, tx_line, rx_valid, par_err;
  logic [7:0] rx_data;
  wire rx_line = loop ? tx_line : drv;

  int checks = 0, fails = 0, got = 0;
  logic [7:0] last_b;
  bit finished = 0;

  sc_char_codec u0 (.clk, .rst_n, .bit_tick, .msb_first, .data_inv, .parity_odd,
    .tx_data, .tx_valid, .tx_ready, .tx_line, .rx_line, .par_err_clr,
    .rx_data, .rx_valid, .par_err);

  always #2.5 clk = ~clk;

  initial begin
    int c = 0;
    forever begin
      @(posedge clk); #1;
      bit_tick = (c == P-1);
      c = (c == P-1) ? 0 : c + 1;
    end
  end

  initial forever begin
    @(negedge clk);
    if (rx_valid) begin got++; last_b = rx_data; end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5ns * 150000);
    fails++;
    $display("FAIL watchdog: act=timeout exp=done");
    finish_run();
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_frame(input logic [7:0] d, input logic rev,
                                           input logic inv, input logic odd);
    logic [7:0] l;
    for (int i = 0; i < 8; i++) l[i] = (rev ? d[7-i] : d[i]) ^ inv;
    return {(^l) ^ odd, l, 1'b0};
  endfunction

  task automatic send(input logic [7:0] d, output logic [9:0] fr, output logic rdy_ok);
    rdy_ok = 1;
    @(negedge clk);
    tx_data = d; tx_valid = 1;
    @(negedge clk);
    tx_valid = 0;
    if (tx_ready !== 1'b0) rdy_ok = 0;
    for (int k = 0; k <= 10; k++) begin
      do @(negedge clk); while (!bit_tick);
      @(negedge clk);
      if (k < 10) begin
        fr[k] = tx_line;
        if (tx_ready !== 1'b0) rdy_ok = 0;
      end else begin
        if (tx_line !== 1'b1 || tx_ready !== 1'b1) rdy_ok = 0;
      end
    end
  endtask

  task automatic drive_frame(input logic [9:0] f);
    loop = 0;
    @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      drv = f[k];
      repeat (P) @(negedge clk);
    end
    drv = 1;
    repeat (2*P) @(negedge clk);
  endtask

  initial begin
    logic [9:0] fr;
    logic ok;
    int g0;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 tx_line", tx_line, 1);
    chk("R1 tx_ready", tx_ready, 1);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 par_err", par_err, 0);
    repeat (3*P) @(negedge clk);

    // R7 direct initial character
    g0 = got;
    send(8'h3B, fr, ok);
    chk("R7 direct frame", fr, 10'b1001110110);
    chk("R2 ready window", ok, 1);
    chk("R8 loopback count", got, g0 + 1);
    chk("R8 loopback byte", last_b, 8'h3B);

    // R7 inverse initial character
    msb_first = 1; data_inv = 1; parity_odd = 1;
    g0 = got;
    send(8'h3F, fr, ok);
    chk("R7 inverse frame", fr, 10'b1000000110);
    chk("R8 inverse byte", last_b, 8'h3F);
    chk("R8 inverse count", got, g0 + 1);
    chk("R9 no error", par_err, 0);

    // R4 R5 R6 random conventions in loopback
    for (int n = 0; n < 24; n++) begin
      logic [7:0] d;
      d = 8'($urandom);
      msb_first = 1'($urandom); data_inv = 1'($urandom); parity_odd = 1'($urandom);
      g0 = got;
      send(d, fr, ok);
      chk("R4 R5 R6 frame", fr, exp_frame(d, msb_first, data_inv, parity_odd));
      chk("R2 R3 handshake", ok, 1);
      chk("R8 rx byte", last_b, d);
      chk("R8 rx count", got, g0 + 1);
    end
    chk("R6 no false error", par_err, 0);

    // R9 parity error, byte delivered, sticky
    msb_first = 0; data_inv = 0; parity_odd = 0;
    fr = exp_frame(8'hA5, 0, 0, 0);
    fr[9] = ~fr[9];
    g0 = got;
    drive_frame(fr);
    chk("R9 bad byte delivered", last_b, 8'hA5);
    chk("R9 count", got, g0 + 1);
    chk("R9 error set", par_err, 1);
    drive_frame(exp_frame(8'h5C, 0, 0, 0));
    chk("R9 byte after error", last_b, 8'h5C);
    chk("R9 sticky", par_err, 1);
    @(negedge clk); par_err_clr = 1;
    @(negedge clk); par_err_clr = 0;
    chk("R9 cleared", par_err, 0);

    // R8 inverse convention on a driven frame
    msb_first = 1; data_inv = 1; parity_odd = 1;
    drive_frame(exp_frame(8'hC4, 1, 1, 1));
    chk("R8 driven inverse byte", last_b, 8'hC4);
    chk("R6 odd parity ok", par_err, 0);

    // R10 false start glitch
    g0 = got;
    @(negedge clk); drv = 0;
    repeat (3) @(negedge clk);
    drv = 1;
    repeat (12*P) @(negedge clk);
    chk("R10 glitch ignored", got, g0);
    chk("R10 no error", par_err, 0);
    drive_frame(exp_frame(8'h81, 1, 1, 1));
    chk("R10 recovers", last_b, 8'h81);

    finish_run();
  end
endmodule